// File: doc/BRIEF.md
# FEC Codeword Error Injector

This block sits in a transmit path directly after a Reed-Solomon encoder and corrupts chosen symbols of outgoing FEC codewords on purpose, so that the receiver's correction and error-counting logic can be exercised over a live link. Symbols are 10 bits wide and arrive one per clock with a valid strobe and a start-of-codeword marker. Each codeword has 528 symbols, seen as 16 back-to-back groups of 33. The stream leaves the block one clock later, either unchanged or with some bits inverted.

Software picks one group, a 33-position symbol selection inside that group (a 32-bit mask for positions 0 to 31 plus a separate flag for position 32) and a 10-bit pattern that is XORed into every selected symbol. Injection runs either on every codeword while a continuous bit is set, or on exactly one codeword through a single-shot bit that the hardware clears again. The settings are captured at each start marker, so a codeword is never corrupted with a mix of old and new settings. A sticky flag reports start markers that arrive before a codeword is complete, and a counter reports how many codewords were selected for corruption.

Top module: `fec_cw_err_inject`

## Requirements
- R1: The outputs `out_valid`, `out_sop` and `out_sym` repeat `in_valid`, `in_valid & in_sop` and `in_sym` one clock later; a symbol that is not targeted leaves unchanged. After reset `out_valid` is 0.
- R2: A valid symbol carrying the start marker is position 0; each following valid symbol is one position further; cycles with `in_valid` low do not advance the position. Position p lies in group p/33 at index p%33.
- R3: In an armed codeword, a symbol is corrupted when its group equals the group field (register 1 bits [27:24]) and either its index is below 32 and the matching bit of register 2 is set, or its index is 32 and register 1 bit 16 is set. Corruption XORs register 1 bits [9:0] into the symbol, so a zero pattern leaves it unchanged.
- R4: While register 0 bit 0 (continuous) is 1, every codeword whose start marker arrives is armed.
- R5: Writing 1 to register 0 bit 1 (single shot) arms exactly the next codeword whose start marker arrives after the write; a codeword already in progress is not touched. The bit reads 0 from the clock after that start marker on.
- R6: Group, position mask, symbol-32 flag and bit pattern are captured at the start marker and used for the whole codeword; writes during a codeword affect only later codewords.
- R7: Valid symbols after position 527 and before the next start marker pass unchanged.
- R8: A start marker before position 527 has been reached restarts counting at position 0 and sets register 4 bit 0, which stays set until a write to register 4 with bit 0 at 1.
- R9: Register 5 counts armed codewords since reset; any write to register 5 clears it.
- R10: Register 3 is a read/write scratch word that has no effect on the data stream.
- R11: All registers read 0 after reset, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input symbol valid |
| in_sop | input | 1 | Input symbol is the first of a codeword |
| in_sym | input | 10 | Input symbol |
| out_valid | output | 1 | Output symbol valid |
| out_sop | output | 1 | Output symbol is the first of a codeword |
| out_sym | output | 10 | Output symbol, possibly corrupted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |

## Verification
The hardest cases to reach are register writes that land while a codeword is half sent: a single-shot request or a change of group and pattern at symbol 100 or 10 of a running codeword. The bench's codeword driver can issue a register write on any chosen symbol cycle, so these races are produced on purpose, and the codeword in progress as well as the one after it are compared with a model that uses the settings captured at each start marker. A truncated codeword followed by a full one covers the resynchronisation path.

// File: rtl/fec_inj_pkg.sv
// Shared definitions for the FEC codeword error injector.
// Assumes a register space of eight 32-bit words at 3-bit addresses.
package fec_inj_pkg;
    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_BITSEL  = 3'd1,
        RA_SYMSEL  = 3'd2,
        RA_SCRATCH = 3'd3,
        RA_STATUS  = 3'd4,
        RA_HITCNT  = 3'd5
    } reg_addr_e;

    localparam int CTRL_CONT_BIT  = 0;
    localparam int CTRL_SHOT_BIT  = 1;
    localparam int BITSEL_LAST    = 16;
    localparam int BITSEL_GRP_LSB = 24;
endpackage

// File: rtl/fec_cw_tracker.sv
// Tracks where the current input symbol sits inside a codeword.
// Assumes the start marker is only meaningful with in_valid; reports a
// start marker that cuts a codeword short as a one-cycle event.
module fec_cw_tracker #(
    parameter int GRP_SYMS = 33,
    parameter int NUM_GRPS = 16,
    localparam int GRP_W = $clog2(NUM_GRPS),
    localparam int IDX_W = $clog2(GRP_SYMS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    output logic             cur_inside,
    output logic [GRP_W-1:0] cur_grp,
    output logic [IDX_W-1:0] cur_idx,
    output logic             early_sop
);
    logic             inside_q;
    logic [GRP_W-1:0] grp_q;
    logic [IDX_W-1:0] idx_q;
    logic             start;
    logic             last_sym;

    assign start = in_valid && in_sop;

    // Position of the symbol now at the input: a start marker forces zero.
    always_comb begin
        if (start) begin
            cur_inside = 1'b1;
            cur_grp    = '0;
            cur_idx    = '0;
        end else begin
            cur_inside = inside_q;
            cur_grp    = grp_q;
            cur_idx    = idx_q;
        end
    end

    assign early_sop = start && inside_q;
    assign last_sym  = (cur_grp == GRP_W'(NUM_GRPS - 1)) && (cur_idx == IDX_W'(GRP_SYMS - 1));

    // Advance the group/index pair on each valid symbol inside a codeword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inside_q <= 1'b0;
            grp_q    <= '0;
            idx_q    <= '0;
        end else if (in_valid && cur_inside) begin
            if (last_sym) begin
                inside_q <= 1'b0;
                grp_q    <= '0;
                idx_q    <= '0;
            end else if (cur_idx == IDX_W'(GRP_SYMS - 1)) begin
                inside_q <= 1'b1;
                grp_q    <= cur_grp + 1'b1;
                idx_q    <= '0;
            end else begin
                inside_q <= 1'b1;
                grp_q    <= cur_grp;
                idx_q    <= cur_idx + 1'b1;
            end
        end
    end

    // R2: position stays inside the codeword geometry
    a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur_inside |-> (int'(cur_idx) < GRP_SYMS && int'(cur_grp) < NUM_GRPS));

    // R2: the symbol after a start marker is position 1
    a_r2_sop_origin: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (inside_q && grp_q == '0 && idx_q == IDX_W'(1)));

    // R2: idle cycles do not move the position
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> ($stable(inside_q) && $stable(grp_q) && $stable(idx_q)));
endmodule

// File: rtl/fec_inj_regs.sv
// Register bank: control, selection fields, scratch, sticky alignment
// flag and armed-codeword counter. Reads are combinational.
// Assumes SYM_W <= 16, GRP_W <= 8, GRP_SYMS <= 33 and CNT_W <= 32.
module fec_inj_regs
    import fec_inj_pkg::*;
#(
    parameter int SYM_W    = 10,
    parameter int GRP_SYMS = 33,
    parameter int NUM_GRPS = 16,
    parameter int CNT_W    = 32,
    localparam int GRP_W  = $clog2(NUM_GRPS),
    localparam int MASK_W = GRP_SYMS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              shot_taken,
    input  logic              align_evt,
    input  logic              cw_hit,
    output logic              cont_en,
    output logic              shot_req,
    output logic [SYM_W-1:0]  bit_mask,
    output logic [MASK_W-1:0] sym_mask,
    output logic              last_sel,
    output logic [GRP_W-1:0]  grp_sel
);
    logic [31:0]      scratch;
    logic             align_err;
    logic [CNT_W-1:0] hit_cnt;
    logic             wdata_unused;

    assign wdata_unused = ^wdata;

    // Hardware events first, then software writes, which take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_en   <= 1'b0;
            shot_req  <= 1'b0;
            bit_mask  <= '0;
            sym_mask  <= '0;
            last_sel  <= 1'b0;
            grp_sel   <= '0;
            scratch   <= '0;
            align_err <= 1'b0;
            hit_cnt   <= '0;
        end else begin
            if (shot_taken) shot_req  <= 1'b0;
            if (align_evt)  align_err <= 1'b1;
            if (cw_hit)     hit_cnt   <= hit_cnt + 1'b1;
            if (wr_en) begin
                case (reg_addr_e'(addr))
                    RA_CTRL: begin
                        cont_en  <= wdata[CTRL_CONT_BIT];
                        shot_req <= wdata[CTRL_SHOT_BIT];
                    end
                    RA_BITSEL: begin
                        bit_mask <= wdata[SYM_W-1:0];
                        last_sel <= wdata[BITSEL_LAST];
                        grp_sel  <= wdata[BITSEL_GRP_LSB +: GRP_W];
                    end
                    RA_SYMSEL:  sym_mask <= wdata[MASK_W-1:0];
                    RA_SCRATCH: scratch  <= wdata;
                    RA_STATUS:  if (wdata[0]) align_err <= 1'b0;
                    RA_HITCNT:  hit_cnt  <= '0;
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_CTRL: begin
                rdata[CTRL_CONT_BIT] = cont_en;
                rdata[CTRL_SHOT_BIT] = shot_req;
            end
            RA_BITSEL: begin
                rdata[SYM_W-1:0]                  = bit_mask;
                rdata[BITSEL_LAST]                = last_sel;
                rdata[BITSEL_GRP_LSB +: GRP_W]    = grp_sel;
            end
            RA_SYMSEL:  rdata[MASK_W-1:0] = sym_mask;
            RA_SCRATCH: rdata             = scratch;
            RA_STATUS:  rdata[0]          = align_err;
            RA_HITCNT:  rdata[CNT_W-1:0]  = hit_cnt;
            default: ;
        endcase
    end

    // R5: a consumed single shot is gone on the next cycle
    a_r5_shot_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_taken && !(wr_en && addr == 3'(RA_CTRL))) |=> !shot_req);

    // R8: the alignment flag only falls on a clearing write
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err && !(wr_en && addr == 3'(RA_STATUS) && wdata[0])) |=> align_err);

    // R9: the counter holds, steps by one, or is cleared
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hit_cnt == $past(hit_cnt) || hit_cnt == CNT_W'($past(hit_cnt) + 1'b1) || hit_cnt == '0));
endmodule

// File: rtl/fec_sym_corrupt.sv
// Decides per symbol whether to corrupt it and registers the output.
// Settings are captured at each start marker; on the marker cycle the
// live register values are used directly so no cycle is lost.
module fec_sym_corrupt #(
    parameter int SYM_W    = 10,
    parameter int GRP_SYMS = 33,
    parameter int NUM_GRPS = 16,
    localparam int GRP_W  = $clog2(NUM_GRPS),
    localparam int IDX_W  = $clog2(GRP_SYMS),
    localparam int MASK_W = GRP_SYMS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [SYM_W-1:0]  in_sym,
    input  logic              cur_inside,
    input  logic [GRP_W-1:0]  cur_grp,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic              cont_en,
    input  logic              shot_req,
    input  logic [SYM_W-1:0]  bit_mask,
    input  logic [MASK_W-1:0] sym_mask,
    input  logic              last_sel,
    input  logic [GRP_W-1:0]  grp_sel,
    output logic              out_valid,
    output logic              out_sop,
    output logic [SYM_W-1:0]  out_sym,
    output logic              shot_taken,
    output logic              cw_hit
);
    logic                start;
    logic                armed_q, arm_now;
    logic [SYM_W-1:0]    bm_q, eff_bm;
    logic [MASK_W-1:0]   mask_q, eff_mask;
    logic                last_q, eff_last;
    logic [GRP_W-1:0]    grp_q, eff_grp;
    logic [GRP_SYMS-1:0] sel_full;
    logic                hit;

    assign start      = in_valid && in_sop;
    assign shot_taken = start && shot_req;
    assign cw_hit     = start && (cont_en || shot_req);

    // Settings in force for the current symbol.
    always_comb begin
        arm_now  = start ? (cont_en || shot_req) : armed_q;
        eff_bm   = start ? bit_mask : bm_q;
        eff_mask = start ? sym_mask : mask_q;
        eff_last = start ? last_sel : last_q;
        eff_grp  = start ? grp_sel  : grp_q;
        sel_full = {eff_last, eff_mask};
        hit      = in_valid && cur_inside && arm_now && (cur_grp == eff_grp) && sel_full[cur_idx];
    end

    // Capture the settings at each start marker for the codeword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            bm_q    <= '0;
            mask_q  <= '0;
            last_q  <= 1'b0;
            grp_q   <= '0;
        end else if (start) begin
            armed_q <= cont_en || shot_req;
            bm_q    <= bit_mask;
            mask_q  <= sym_mask;
            last_q  <= last_sel;
            grp_q   <= grp_sel;
        end
    end

    // One-cycle output stage with the optional XOR pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= in_valid;
            out_sop   <= start;
            out_sym   <= in_sym ^ (hit ? eff_bm : '0);
        end
    end

    // R1: valid follows the input by exactly one cycle
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R3: a changed symbol needs an armed codeword in progress
    a_r3_change_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && out_sym != $past(in_sym)) |-> $past(arm_now && cur_inside));

    // R7: symbols outside any codeword are never altered
    a_r7_outside_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cur_inside) |=> (out_sym == $past(in_sym)));
endmodule

// File: rtl/fec_cw_err_inject.sv
// Top of the FEC codeword error injector: position tracker, register
// bank and corruption stage. Assumes one symbol per clock at most and a
// start marker on the first symbol of every codeword.
module fec_cw_err_inject #(
    parameter int SYM_W    = 10,
    parameter int GRP_SYMS = 33,
    parameter int NUM_GRPS = 16,
    parameter int CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [SYM_W-1:0] in_sym,
    output logic             out_valid,
    output logic             out_sop,
    output logic [SYM_W-1:0] out_sym,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata
);
    localparam int GRP_W  = $clog2(NUM_GRPS);
    localparam int IDX_W  = $clog2(GRP_SYMS);
    localparam int MASK_W = GRP_SYMS - 1;

    logic              cur_inside;
    logic [GRP_W-1:0]  cur_grp;
    logic [IDX_W-1:0]  cur_idx;
    logic              early_sop;
    logic              shot_taken, cw_hit;
    logic              cont_en, shot_req, last_sel;
    logic [SYM_W-1:0]  bit_mask;
    logic [MASK_W-1:0] sym_mask;
    logic [GRP_W-1:0]  grp_sel;

    fec_cw_tracker #(.GRP_SYMS(GRP_SYMS), .NUM_GRPS(NUM_GRPS)) trk_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .cur_inside(cur_inside), .cur_grp(cur_grp), .cur_idx(cur_idx),
        .early_sop(early_sop)
    );

    fec_inj_regs #(.SYM_W(SYM_W), .GRP_SYMS(GRP_SYMS), .NUM_GRPS(NUM_GRPS), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .shot_taken(shot_taken),
        .align_evt(early_sop), .cw_hit(cw_hit), .cont_en(cont_en),
        .shot_req(shot_req), .bit_mask(bit_mask), .sym_mask(sym_mask),
        .last_sel(last_sel), .grp_sel(grp_sel)
    );

    fec_sym_corrupt #(.SYM_W(SYM_W), .GRP_SYMS(GRP_SYMS), .NUM_GRPS(NUM_GRPS)) cor_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_sym(in_sym), .cur_inside(cur_inside), .cur_grp(cur_grp),
        .cur_idx(cur_idx), .cont_en(cont_en), .shot_req(shot_req),
        .bit_mask(bit_mask), .sym_mask(sym_mask), .last_sel(last_sel),
        .grp_sel(grp_sel), .out_valid(out_valid), .out_sop(out_sop),
        .out_sym(out_sym), .shot_taken(shot_taken), .cw_hit(cw_hit)
    );
endmodule

// File: tb/fec_cw_err_inject_tb.sv
// Self-checking bench for the FEC codeword error injector.
module fec_cw_err_inject_tb_top;
    import fec_inj_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0;
    logic [9:0]  in_sym = '0;
    logic        out_valid, out_sop;
    logic [9:0]  out_sym;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #4 clk = ~clk;

    fec_cw_err_inject dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_sym(in_sym), .out_valid(out_valid), .out_sop(out_sop),
        .out_sym(out_sym), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int checks = 0, errors = 0, exp_hits = 0, cw_err = 0;
    bit done = 1'b0;

    // Model settings for the codeword about to be sent.
    logic [3:0]  m_grp;
    logic [31:0] m_mask;
    logic        m_last;
    logic [9:0]  m_bm;
    logic        pv = 1'b0, ps = 1'b0;
    logic [9:0]  pe = '0;

    // Table: {group[46:43], symbol mask[42:11], symbol-32 flag[10], pattern[9:0]}
    localparam logic [46:0] VEC [6] = '{
        {4'd0,  32'h0000_0001, 1'b0, 10'h3FF},
        {4'd15, 32'h0000_0000, 1'b1, 10'h001},
        {4'd7,  32'hAAAA_5555, 1'b1, 10'h2A5},
        {4'd3,  32'hFFFF_FFFF, 1'b0, 10'h200},
        {4'd9,  32'h8000_0000, 1'b0, 10'h000},
        {4'd12, 32'h0F0F_0F0F, 1'b1, 10'h155}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // One clock: compare the output of the previous symbol, drive the next.
    task automatic step(input logic v, input logic s, input logic [9:0] sym, input logic [9:0] e);
        @(negedge clk);
        if (out_valid !== pv || (pv && (out_sop !== ps || out_sym !== pe))) cw_err++;
        in_valid = v; in_sop = s; in_sym = sym;
        pv = v; ps = v && s; pe = e;
    endtask

    task automatic send_cw(input int len, input bit gaps, input bit armed, input int mid_at,
                           input logic [2:0] mid_addr, input logic [31:0] mid_data, input string req);
        logic [9:0] sym;
        bit h;
        cw_err = 0;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 5 == 4)) step(1'b0, 1'b0, 10'h155, 10'h155);
            sym = 10'(i * 37 + 11);
            h = armed && (i < 528) && ((i / 33) == int'(m_grp)) &&
                (((i % 33) == 32) ? m_last : m_mask[i % 33]);
            step(1'b1, i == 0, sym, h ? (sym ^ m_bm) : sym);
            reg_wr = 1'b0;
            if (i == mid_at) begin
                reg_wr = 1'b1; reg_addr = mid_addr; reg_wdata = mid_data;
            end
        end
        step(1'b0, 1'b0, 10'h0, 10'h0);
        reg_wr = 1'b0;
        if (armed) exp_hits++;
        check(cw_err == 0, req, "symbol mismatches in codeword", cw_err, 0);
    endtask

    task automatic set_cfg(input logic [3:0] g, input logic [31:0] m, input logic l, input logic [9:0] b);
        m_grp = g; m_mask = m; m_last = l; m_bm = b;
        wr(3'(RA_BITSEL), {4'h0, g, 7'h0, l, 6'h0, b});
        wr(3'(RA_SYMSEL), m);
    endtask

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1, R11: reset state
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check(d == 32'h0, "R11", "register after reset", d, 0);
        end

        // R3, R4: table of settings in continuous mode
        wr(3'(RA_CTRL), 32'h1);
        for (int v = 0; v < 6; v++) begin
            set_cfg(VEC[v][46:43], VEC[v][42:11], VEC[v][10], VEC[v][9:0]);
            send_cw(528, 1'b0, 1'b1, -1, 3'h0, 32'h0, "R3");
        end
        rd(3'(RA_HITCNT), d);
        check(d == 32'd6, "R4", "codewords armed in continuous mode", d, 6);

        // R2: idle cycles inside a codeword
        send_cw(528, 1'b1, 1'b1, -1, 3'h0, 32'h0, "R2");
        // R7: trailing symbols past position 527
        send_cw(535, 1'b0, 1'b1, -1, 3'h0, 32'h0, "R7");

        // R6: settings change at symbol 10 of a running codeword
        set_cfg(4'd2, 32'hFFFF_FFFF, 1'b1, 10'h00F);
        send_cw(528, 1'b0, 1'b1, 10, 3'(RA_BITSEL), {4'h0, 4'd3, 24'h0000_30}, "R6");
        m_grp = 4'd3; m_last = 1'b0; m_bm = 10'h030;
        send_cw(528, 1'b0, 1'b1, -1, 3'h0, 32'h0, "R6");

        // R10: scratch read/write without effect on the stream
        wr(3'(RA_SCRATCH), 32'hA5A5_5A5A);
        rd(3'(RA_SCRATCH), d);
        check(d == 32'hA5A5_5A5A, "R10", "scratch readback", d, 32'hA5A5_5A5A);
        send_cw(528, 1'b0, 1'b1, -1, 3'h0, 32'h0, "R10");

        // R8: truncated codeword, resynchronisation, sticky flag
        rd(3'(RA_STATUS), d);
        check(d == 32'h0, "R8", "status before early marker", d, 0);
        send_cw(100, 1'b0, 1'b1, -1, 3'h0, 32'h0, "R8");
        send_cw(528, 1'b0, 1'b1, -1, 3'h0, 32'h0, "R8");
        rd(3'(RA_STATUS), d);
        check(d == 32'h1, "R8", "status after early marker", d, 1);
        wr(3'(RA_STATUS), 32'h0);
        rd(3'(RA_STATUS), d);
        check(d == 32'h1, "R8", "status after non-clearing write", d, 1);
        wr(3'(RA_STATUS), 32'h1);
        rd(3'(RA_STATUS), d);
        check(d == 32'h0, "R8", "status after clearing write", d, 0);

        // R5: single shot, self clear, deferred arming
        wr(3'(RA_CTRL), 32'h0);
        send_cw(528, 1'b0, 1'b0, -1, 3'h0, 32'h0, "R5");
        wr(3'(RA_CTRL), 32'h2);
        rd(3'(RA_CTRL), d);
        check(d == 32'h2, "R5", "single shot pending", d, 2);
        send_cw(528, 1'b0, 1'b1, -1, 3'h0, 32'h0, "R5");
        rd(3'(RA_CTRL), d);
        check(d == 32'h0, "R5", "single shot cleared", d, 0);
        send_cw(528, 1'b0, 1'b0, -1, 3'h0, 32'h0, "R5");
        send_cw(528, 1'b0, 1'b0, 100, 3'(RA_CTRL), 32'h2, "R5");
        send_cw(528, 1'b0, 1'b1, -1, 3'h0, 32'h0, "R5");
        rd(3'(RA_CTRL), d);
        check(d == 32'h0, "R5", "deferred shot cleared", d, 0);

        // R9: armed-codeword counter and its clear
        rd(3'(RA_HITCNT), d);
        check(d == 32'(exp_hits), "R9", "armed codeword count", d, exp_hits);
        wr(3'(RA_HITCNT), 32'h0);
        rd(3'(RA_HITCNT), d);
        check(d == 32'h0, "R9", "count after clear", d, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule